// File: doc/BRIEF.md
# Partitioned Packed-Arithmetic Adder

This block adds or subtracts two 64-bit operands that it treats as packed vectors of independent elements. The element width is chosen per operation by a field in the opcode: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Every operation covers the whole 64-bit word with unit stride. There is no separate length setting. One ripple of byte-wide adder slices serves all four widths. The carry between two neighbouring slices is cut wherever the selected width places an element boundary.

Each element can wrap modulo its width, or it can clamp to its own limits. The limits are unsigned or signed, as the opcode chooses. A per-byte flag vector reports carry, borrow or signed overflow at the most significant byte of each element. The datapath is combinational and feeds one output register stage, so a result appears one cycle after its strobe.

Top module: `packed_addsub`

## Requirements
- R1: `in_op[1:0]` selects the element width: 0 gives eight 8-bit elements, 1 gives four 16-bit elements, 2 gives two 32-bit elements and 3 gives one 64-bit element. All 64 bits are processed in every operation.
- R2: No carry or borrow ever passes from one element into the next element up. Each element's result depends only on that element's own operand bits.
- R3: With `in_op[2]`=1, each element computes a minus b. This is done by inverting b and forcing a carry-in of 1 into the element's lowest byte. With `in_op[2]`=0, each element computes a plus b.
- R4: With `in_op[3]`=0, each element's result is the exact sum or difference modulo 2 to the power of the element width.
- R5: With `in_op[3]`=1 and `in_op[4]`=0, an element whose unsigned add carries out becomes all ones. An element whose unsigned subtract borrows becomes zero.
- R6: With `in_op[3]`=1 and `in_op[4]`=1, an element whose signed result overflows becomes the signed maximum (0x7F..F) when a is non-negative. It becomes the signed minimum (0x80..0) when a is negative.
- R7: `out_flag[k]` may be 1 only when byte k is the most significant byte of its element. There it is the signed overflow if `in_op[4]`=1. Otherwise it is the carry-out for an add or the borrow for a subtract. The flag does not depend on `in_op[3]`.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock. `out_result` and `out_flag` load only when `in_valid` is 1 and hold otherwise.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| in_a | input | 64 | Packed operand a |
| in_b | input | 64 | Packed operand b |
| in_op | input | 5 | [1:0] width, [2] subtract, [3] saturate, [4] signed |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Packed result |
| out_flag | output | 8 | Per-byte carry/borrow/overflow, top byte of each element only |

## Verification
On every cycle, the assertions check the following:
- the one-cycle strobe latency and the reset clearing;
- that a full-width operation never raises a flag below its top byte;
- that the top byte in 8-bit wrap-add mode equals the plain byte sum of its own operand bytes, so no carry enters from below;
- that an unsigned saturating 64-bit add never returns less than operand a.

Some properties cannot be expressed as a one-line property. These need the bench's vectors, which it compares against an element-by-element model:
- exact clamp values for signed and unsigned saturation;
- correct flag placement for 16-bit and 32-bit elements;
- isolation between elements under all-ones carry patterns in every width.

// File: rtl/paddsub_pkg.sv
package paddsub_pkg;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_B16 = 2'd1,
    ESZ_B32 = 2'd2,
    ESZ_B64 = 2'd3
  } elem_size_e;

  // Opcode layout: {signed, saturate, subtract, size}
  typedef struct packed {
    logic       sgn;
    logic       sat;
    logic       sub;
    elem_size_e size;
  } paddsub_op_t;

endpackage

// File: rtl/paddsub_seg.sv
// Marks, per byte slice, whether it is the lowest or highest byte of its element.
module paddsub_seg
  import paddsub_pkg::*;
#(
  parameter int NB = 8
) (
  input  elem_size_e    size,
  output logic [NB-1:0] lo,
  output logic [NB-1:0] hi
);
  for (genvar i = 0; i < NB; i++) begin : g_mark
    logic [31:0] span_m;
    assign span_m = (32'd1 << int'(size)) - 32'd1;
    assign lo[i]  = ((32'(i) & span_m) == 32'd0);
    assign hi[i]  = ((32'(i) & span_m) == span_m);
  end
endmodule

// File: rtl/paddsub_chain.sv
// Byte-slice ripple with carry cut at element starts.
module paddsub_chain #(
  parameter int NB = 8,
  parameter int BW = 8,
  localparam int W = NB * BW
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          sub,
  input  logic [NB-1:0] lo,
  output logic [W-1:0]  sum,
  output logic [NB-1:0] cout,
  output logic [NB-1:0] sovf
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic          cin;
    logic [BW-1:0] bx;
    logic [BW:0]   s;
    if (i == 0) begin : g_lsb
      assign cin = lo[0] ? sub : 1'b0;
    end else begin : g_up
      assign cin = lo[i] ? sub : g_byte[i-1].s[BW];
    end
    assign bx = sub ? ~b[i*BW +: BW] : b[i*BW +: BW];
    assign s  = {1'b0, a[i*BW +: BW]} + {1'b0, bx} + {{BW{1'b0}}, cin};
    assign sum[i*BW +: BW] = s[BW-1:0];
    assign cout[i] = s[BW];
    assign sovf[i] = (a[i*BW+BW-1] == bx[BW-1]) && (s[BW-1] != a[i*BW+BW-1]);
  end
endmodule

// File: rtl/paddsub_sat.sv
// Broadcasts each element's overflow and sign downward and applies clamping.
module paddsub_sat #(
  parameter int NB = 8,
  parameter int BW = 8,
  localparam int W = NB * BW
) (
  input  logic [W-1:0]  sum,
  input  logic [NB-1:0] hi,
  input  logic [NB-1:0] fraw,
  input  logic [NB-1:0] amsb,
  input  logic          sat,
  input  logic          sgn,
  input  logic          sub,
  output logic [W-1:0]  res
);
  for (genvar i = NB - 1; i >= 0; i--) begin : g_sl
    logic          hit;
    logic          neg;
    logic [BW-1:0] fill;
    if (i == NB - 1) begin : g_top
      assign hit = hi[i] ? fraw[i] : 1'b0;
      assign neg = hi[i] ? amsb[i] : 1'b0;
    end else begin : g_dn
      assign hit = hi[i] ? fraw[i] : g_sl[i+1].hit;
      assign neg = hi[i] ? amsb[i] : g_sl[i+1].neg;
    end
    always_comb begin
      if (sgn) begin
        if (hi[i]) fill = {neg, {(BW-1){~neg}}};
        else       fill = {BW{~neg}};
      end else begin
        fill = {BW{~sub}};
      end
    end
    assign res[i*BW +: BW] = (sat && hit) ? fill : sum[i*BW +: BW];
  end
endmodule

// File: rtl/packed_addsub.sv
module packed_addsub
  import paddsub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [4:0]        in_op,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [NB-1:0]     out_flag
);
  paddsub_op_t op;
  assign op = paddsub_op_t'(in_op);

  logic [NB-1:0]     lo, hi, cout, sovf, fraw, amsb;
  logic [DATA_W-1:0] sum, res;
  elem_size_e        r_size;

  paddsub_seg #(.NB(NB)) u_seg (.size(op.size), .lo(lo), .hi(hi));

  paddsub_chain #(.NB(NB), .BW(BYTE_W)) u_chain (
    .a(in_a), .b(in_b), .sub(op.sub), .lo(lo),
    .sum(sum), .cout(cout), .sovf(sovf)
  );

  for (genvar i = 0; i < NB; i++) begin : g_flag
    assign fraw[i] = op.sgn ? sovf[i] : (cout[i] ^ op.sub);
    assign amsb[i] = in_a[i*BYTE_W + BYTE_W - 1];
  end

  paddsub_sat #(.NB(NB), .BW(BYTE_W)) u_sat (
    .sum(sum), .hi(hi), .fraw(fraw), .amsb(amsb),
    .sat(op.sat), .sgn(op.sgn), .sub(op.sub), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flag   <= '0;
      r_size     <= ESZ_B8;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res;
        out_flag   <= hi & fraw;
        r_size     <= op.size;
      end
    end
  end

  // R8: strobe latency of exactly one cycle
  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: reset clears outputs
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_flag == '0 && out_result == '0));

  // R7: single full-width element only flags its top byte
  assert_flag_top_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && r_size == ESZ_B64) |-> (out_flag[NB-2:0] == '0));

  // R2: top byte in 8-bit wrap-add equals its own byte sum, no carry from below
  assert_no_carry_in_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 5'b00000) |=>
      (out_result[DATA_W-1 -: BYTE_W] ==
       BYTE_W'($past(in_a[DATA_W-1 -: BYTE_W]) + $past(in_b[DATA_W-1 -: BYTE_W]))));

  // R5: unsigned saturating full-width add never drops below a
  assert_usat_floor_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 5'b01011) |=> (out_result >= $past(in_a)));

endmodule

// File: tb/tb_packed_addsub.sv
`timescale 1ns/1ps
module tb_packed_addsub;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic [4:0]  in_op = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [7:0]  out_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  packed_addsub dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_op(in_op), .out_valid(out_valid), .out_result(out_result), .out_flag(out_flag)
  );

  // {op, a, b}; op = {signed, saturate, subtract, size}
  localparam logic [132:0] VEC [NV] = '{
    {5'b00000, 64'h0102_0304_0506_0708, 64'h10FF_2030_4050_6070},
    {5'b00001, 64'hFFFF_0001_8000_7FFF, 64'h0001_0001_8000_0001},
    {5'b00010, 64'hFFFF_FFFF_1234_5678, 64'h0000_0001_EDCB_A988},
    {5'b00011, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {5'b00100, 64'h0010_2030_4050_6070, 64'h0111_1020_3040_8001},
    {5'b00111, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001},
    {5'b01000, 64'hF0F0_1010_FFFF_0000, 64'h2020_2020_0101_FFFF},
    {5'b01101, 64'h0005_1000_FFFF_0000, 64'h0006_0FFF_0001_0001},
    {5'b11000, 64'h7F7F_8080_0102_7E81, 64'h0101_FFFF_FEFF_0280},
    {5'b11110, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF},
    {5'b10001, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_1111_0001},
    {5'b11011, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005}
  };

  // Element-wise reference model: returns {flags, result}
  function automatic logic [71:0] model(logic [63:0] a, logic [63:0] b, logic [4:0] op);
    int          w   = 8 << op[1:0];
    logic        sub = op[2];
    logic        sat = op[3];
    logic        sgn = op[4];
    logic [64:0] mask = (65'd1 << w) - 65'd1;
    logic [63:0] r = '0;
    logic [7:0]  f = '0;
    for (int e = 0; e < 64 / w; e++) begin
      logic [64:0] av = ({1'b0, a} >> (e * w)) & mask;
      logic [64:0] bv = ({1'b0, b} >> (e * w)) & mask;
      logic [64:0] be = sub ? (~bv & mask) : bv;
      logic [64:0] sm = av + be + {64'd0, sub};
      logic [64:0] rv = sm & mask;
      logic        sa = av[w-1];
      logic        ov = (sa == be[w-1]) && (sm[w-1] != sa);
      logic        uf = sm[w] ^ sub;
      logic        fl = sgn ? ov : uf;
      if (sat && fl) begin
        if (sgn) rv = sa ? (65'd1 << (w - 1)) : (mask >> 1);
        else     rv = sub ? 65'd0 : mask;
      end
      r = r | (64'(rv) << (e * w));
      f[(e * w) / 8 + w / 8 - 1] = fl;
    end
    return {f, r};
  endfunction

  function automatic string tag_of(logic [4:0] op);
    if (op[3] && op[4]) return "R6";
    if (op[3])          return "R5";
    if (op[2])          return "R3";
    return "R4";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Drive at negedge; registered result is checked at the following negedge.
  task automatic apply(logic [63:0] a, logic [63:0] b, logic [4:0] op);
    @(negedge clk);
    in_a = a; in_b = b; in_op = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(string req, logic [63:0] a, logic [63:0] b, logic [4:0] op);
    logic [71:0] m = model(a, b, op);
    apply(a, b, op);
    check("R8", {63'd0, out_valid}, 64'd1);
    check(req, out_result, m[63:0]);
    check("R7", {56'd0, out_flag}, {56'd0, m[71:64]});
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    check("R9", {55'd0, out_valid, out_flag}, 64'd0);
    check("R9", out_result, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_op(tag_of(VEC[i][132:128]), VEC[i][127:64], VEC[i][63:0], VEC[i][132:128]);
    end

    // R2 / R1: all-ones plus one in each width
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00000);
    check("R2", out_result, 64'hFFFF_FFFF_FFFF_FF00);
    check("R2", {56'd0, out_flag}, 64'h01);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00001);
    check("R1", out_result, 64'hFFFF_FFFF_FFFF_0000);
    check("R1", {56'd0, out_flag}, 64'h02);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00010);
    check("R1", out_result, 64'hFFFF_FFFF_0000_0000);
    check("R1", {56'd0, out_flag}, 64'h08);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00011);
    check("R1", out_result, 64'd0);
    check("R1", {56'd0, out_flag}, 64'h80);

    // R3: byte subtract borrow stays inside each lane
    apply(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 5'b00100);
    check("R3", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3", {56'd0, out_flag}, 64'hFF);

    // R5 / R6 clamp endpoints
    apply(64'hFF00_FF00_FF00_FF00, 64'h0101_0101_0101_0101, 5'b01000);
    check("R5", out_result, 64'hFF01_FF01_FF01_FF01);
    apply(64'h8000_0000_0000_0000, 64'd1, 5'b11111);
    check("R6", out_result, 64'h8000_0000_0000_0000);

    // R8: output holds and strobe drops one cycle after in_valid falls
    in_a = 64'h1234; in_b = 64'h1; in_op = 5'b00011;
    @(negedge clk);
    check("R8", {63'd0, out_valid}, 64'd0);
    check("R8", out_result, 64'h8000_0000_0000_0000);

    // R9: reset mid-run clears results
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", out_result, 64'd0);

    done = 1'b1;
    finish_run();
  end
endmodule